// File: doc/BRIEF.md
# Watchdog Timer with Selectable Reset Target

This block is a software-serviced watchdog. Software sets a reload value and, while the watchdog is enabled, a down-counter loses one unit each time a programmable time base elapses. Any write of the reload value refills the counter and restarts the time base; this write is the kick. If software fails to kick in time, the counter reaches zero and the block pulses a reset for a fixed number of clock cycles, then switches itself off.

The expiry action is chosen by a control bit. With the bit clear the block pulses a board-level reset. With it set the block pulses a request for a backplane system reset. When the board acts as the backplane system controller (a strap input), a board-level reset is also driven onto the backplane reset request. The time base is a base period shifted left by a 3-bit resolution field, so the steps are powers of two. With a 1 ms base the eight steps run from 1 ms to 128 ms, which includes 32 ms and 64 ms. Simulation shrinks the base period through a parameter. Software can read the remaining count at any time.

Top module: `wdt_reset_sel`

## Requirements
- R1: After reset both reset outputs are low. The enable and target bits read 0 and the resolution reads 0. The reload value and the count both read `LOAD_RST`, which defaults to 0xFFFF.
- R2: A write to address 0 stores the reload value and loads it into the counter, whether the watchdog is enabled or not. It also restarts the time base. Kicking before expiry postpones expiry by a full reload interval, counted from the kick.
- R3: The tick period is `TICK_BASE << res` cycles, where `res` is bits [2:0] of address 2. While enabled, the count drops by one per tick. With reload value N > 0, expiry occurs N*period cycles after the enabling write or kick. With N = 0 it occurs after one period.
- R4: Clearing the enable bit (address 1, bit 0) stops the count where it is, and no reset is issued.
- R5: With the target bit (address 1, bit 1) clear and the system-controller input low, expiry pulses only `board_rst_o`.
- R6: With the target bit set, expiry pulses only `bp_rst_o`, whatever the system-controller input is.
- R7: With the target bit clear and the system-controller input high, expiry pulses both `board_rst_o` and `bp_rst_o`.
- R8: The reset pulse is high for exactly `PULSE_LEN` cycles. It starts on the clock edge at which the count reaches zero.
- R9: Expiry clears the enable bit, and the count then reads 0.
- R10: A read is requested with `rd_en_i`. Its data appears on `rd_data_o` one clock later. Address 0 returns the reload value, address 1 returns {target, enable} in bits [1:0], address 2 returns the resolution in bits [2:0], and address 3 returns the remaining count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address |
| wr_data_i | input | CNT_W | Write data |
| rd_en_i | input | 1 | Register read strobe |
| rd_addr_i | input | 2 | Read address |
| rd_data_o | output | CNT_W | Read data, one cycle after the strobe |
| sys_ctrl_i | input | 1 | High when the board is the backplane system controller |
| board_rst_o | output | 1 | Board-level reset pulse |
| bp_rst_o | output | 1 | Backplane system reset request pulse |

## Verification
A wrong count or prescaler state shows up at the ports as a reset edge that arrives earlier or later than N*period cycles after the start. The error is visible to the cycle on the first expiry, or through the count readback one cycle after a read. A wrongly held target or system-controller latch shows up as the wrong output, or as the right output with the wrong width, during the first pulse. An enable bit that fails to clear after expiry, or a count that still moves while disabled, shows up in the next readback, or as a reset that should never have fired.

// File: rtl/wdt_reset_pkg.sv
package wdt_reset_pkg;
  typedef enum logic [1:0] {
    REG_RELOAD = 2'd0,
    REG_CTRL   = 2'd1,
    REG_RES    = 2'd2,
    REG_COUNT  = 2'd3
  } wdt_reg_e;

  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_TGT_BIT = 1;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_reset_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int RES_W = 3,
  parameter logic [CNT_W-1:0] LOAD_RST = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             rd_en_i,
  input  logic [1:0]       rd_addr_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             expire_i,
  output logic [CNT_W-1:0] rd_data_o,
  output logic [CNT_W-1:0] reload_o,
  output logic             kick_o,
  output logic             enable_o,
  output logic             target_bp_o,
  output logic [RES_W-1:0] res_o
);
  logic [CNT_W-1:0] reload_q;
  logic             en_q;
  logic             tgt_q;
  logic [RES_W-1:0] res_q;
  logic             wr_ctrl;

  assign kick_o  = wr_en_i && (wdt_reg_e'(wr_addr_i) == REG_RELOAD);
  assign wr_ctrl = wr_en_i && (wdt_reg_e'(wr_addr_i) == REG_CTRL);

  always_ff @(posedge clk) begin
    if (rst) begin
      reload_q <= LOAD_RST;
      en_q     <= 1'b0;
      tgt_q    <= 1'b0;
      res_q    <= '0;
    end else begin
      if (kick_o) reload_q <= wr_data_i;
      if (wr_ctrl) tgt_q <= wr_data_i[CTRL_TGT_BIT];
      if (expire_i) en_q <= 1'b0;
      else if (wr_ctrl) en_q <= wr_data_i[CTRL_EN_BIT];
      if (wr_en_i && (wdt_reg_e'(wr_addr_i) == REG_RES))
        res_q <= wr_data_i[RES_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data_o <= '0;
    end else if (rd_en_i) begin
      rd_data_o <= '0;
      case (wdt_reg_e'(rd_addr_i))
        REG_RELOAD: rd_data_o <= reload_q;
        REG_CTRL: begin
          rd_data_o[CTRL_EN_BIT]  <= en_q;
          rd_data_o[CTRL_TGT_BIT] <= tgt_q;
        end
        REG_RES:   rd_data_o[RES_W-1:0] <= res_q;
        default:   rd_data_o <= count_i;
      endcase
    end
  end

  assign reload_o    = reload_q;
  assign enable_o    = en_q;
  assign target_bp_o = tgt_q;
  assign res_o       = res_q;

  // R9: an expiry always leaves the watchdog disabled
  a_r9_self_disable: assert property (@(posedge clk) disable iff (rst)
    expire_i |=> !en_q);
endmodule

// File: rtl/wdt_tick_gen.sv
module wdt_tick_gen #(
  parameter int TICK_BASE = 100000,
  parameter int RES_W     = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic [RES_W-1:0] res_i,
  output logic             tick_o
);
  localparam int PW = $clog2(TICK_BASE + 1) + (1 << RES_W);

  logic [PW-1:0] pre_q;
  logic [PW-1:0] period;
  logic          at_end;

  assign period = PW'(TICK_BASE) << res_i;
  assign at_end = (pre_q >= period - PW'(1));
  assign tick_o = run_i && !restart_i && at_end;

  always_ff @(posedge clk) begin
    if (rst || !run_i || restart_i) pre_q <= '0;
    else if (at_end)                pre_q <= '0;
    else                            pre_q <= pre_q + PW'(1);
  end

  // R3: a stopped time base stays at its start point
  a_r3_idle_cleared: assert property (@(posedge clk) disable iff (rst)
    !run_i |=> (pre_q == '0));
endmodule

// File: rtl/wdt_down_counter.sv
module wdt_down_counter #(
  parameter int CNT_W = 16,
  parameter logic [CNT_W-1:0] LOAD_RST = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic             kick_i,
  input  logic [CNT_W-1:0] load_i,
  output logic [CNT_W-1:0] count_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;

  assign expire_o = en_i && tick_i && !kick_i && (cnt_q <= CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst)                        cnt_q <= LOAD_RST;
    else if (kick_i)                cnt_q <= load_i;
    else if (expire_o)              cnt_q <= '0;
    else if (en_i && tick_i)        cnt_q <= cnt_q - CNT_W'(1);
  end

  assign count_o = cnt_q;

  // R4: with the watchdog off and no kick, the count holds
  a_r4_hold_when_off: assert property (@(posedge clk) disable iff (rst)
    (!en_i && !kick_i) |=> $stable(cnt_q));
  // R3: each tick takes exactly one unit off a non-zero count
  a_r3_single_step: assert property (@(posedge clk) disable iff (rst)
    (en_i && tick_i && !kick_i && cnt_q > CNT_W'(1)) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
endmodule

// File: rtl/wdt_rst_pulse.sv
module wdt_rst_pulse #(
  parameter int PULSE_LEN = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic expire_i,
  input  logic bp_sel_i,
  input  logic sys_ctrl_i,
  output logic board_rst_o,
  output logic bp_rst_o
);
  localparam int LW = $clog2(PULSE_LEN + 1);

  logic [LW-1:0] left_q;
  logic          board_q;
  logic          bp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q  <= '0;
      board_q <= 1'b0;
      bp_q    <= 1'b0;
    end else if (expire_i) begin
      left_q  <= LW'(PULSE_LEN - 1);
      board_q <= !bp_sel_i;
      bp_q    <= bp_sel_i || sys_ctrl_i;
    end else if (left_q != '0) begin
      left_q <= left_q - LW'(1);
    end else begin
      board_q <= 1'b0;
      bp_q    <= 1'b0;
    end
  end

  assign board_rst_o = board_q;
  assign bp_rst_o    = bp_q;

  // R5, R6: a board reset only starts when the local target was chosen
  a_r5_local_target: assert property (@(posedge clk) disable iff (rst)
    $rose(board_rst_o) |-> $past(!bp_sel_i));
  // R7: as system controller, a board reset also raises the backplane request
  a_r7_syscon_both: assert property (@(posedge clk) disable iff (rst)
    ($rose(board_rst_o) && $past(sys_ctrl_i)) |-> bp_rst_o);
endmodule

// File: rtl/wdt_reset_sel.sv
module wdt_reset_sel
  import wdt_reset_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int RES_W     = 3,
  parameter int TICK_BASE = 100000,
  parameter int PULSE_LEN = 16,
  parameter logic [CNT_W-1:0] LOAD_RST = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             rd_en_i,
  input  logic [1:0]       rd_addr_i,
  output logic [CNT_W-1:0] rd_data_o,
  input  logic             sys_ctrl_i,
  output logic             board_rst_o,
  output logic             bp_rst_o
);
  logic [CNT_W-1:0] reload;
  logic [CNT_W-1:0] count;
  logic [RES_W-1:0] res;
  logic             kick;
  logic             enable;
  logic             target_bp;
  logic             tick;
  logic             expire;

  wdt_regs #(.CNT_W(CNT_W), .RES_W(RES_W), .LOAD_RST(LOAD_RST)) regs_i (
    .clk(clk), .rst(rst),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .rd_en_i(rd_en_i), .rd_addr_i(rd_addr_i),
    .count_i(count), .expire_i(expire),
    .rd_data_o(rd_data_o), .reload_o(reload), .kick_o(kick),
    .enable_o(enable), .target_bp_o(target_bp), .res_o(res)
  );

  wdt_tick_gen #(.TICK_BASE(TICK_BASE), .RES_W(RES_W)) tick_i (
    .clk(clk), .rst(rst), .run_i(enable), .restart_i(kick),
    .res_i(res), .tick_o(tick)
  );

  wdt_down_counter #(.CNT_W(CNT_W), .LOAD_RST(LOAD_RST)) cnt_i (
    .clk(clk), .rst(rst), .en_i(enable), .tick_i(tick), .kick_i(kick),
    .load_i(wr_data_i), .count_o(count), .expire_o(expire)
  );

  wdt_rst_pulse #(.PULSE_LEN(PULSE_LEN)) pulse_i (
    .clk(clk), .rst(rst), .expire_i(expire), .bp_sel_i(target_bp),
    .sys_ctrl_i(sys_ctrl_i), .board_rst_o(board_rst_o), .bp_rst_o(bp_rst_o)
  );

  // R8: a reset pulse only begins on the edge that ends the count
  a_r8_start_on_expiry: assert property (@(posedge clk) disable iff (rst)
    $rose(board_rst_o || bp_rst_o) |-> $past(expire));
  // R2: a kick puts the written value straight into the counter
  a_r2_kick_loads: assert property (@(posedge clk) disable iff (rst)
    kick |=> (count == $past(wr_data_i)));
endmodule

// File: tb/wdt_reset_sel_tb_top.sv
module wdt_reset_sel_tb_top;
  localparam int CNT_W = 16;
  localparam int TB_TICK = 3;
  localparam int TB_PULSE = 5;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             wr_en_i = 1'b0;
  logic [1:0]       wr_addr_i = '0;
  logic [CNT_W-1:0] wr_data_i = '0;
  logic             rd_en_i = 1'b0;
  logic [1:0]       rd_addr_i = '0;
  logic [CNT_W-1:0] rd_data_o;
  logic             sys_ctrl_i = 1'b0;
  logic             board_rst_o;
  logic             bp_rst_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  wdt_reset_sel #(.CNT_W(CNT_W), .TICK_BASE(TB_TICK), .PULSE_LEN(TB_PULSE)) dut_i (
    .clk(clk), .rst(rst),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .rd_en_i(rd_en_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
    .sys_ctrl_i(sys_ctrl_i), .board_rst_o(board_rst_o), .bp_rst_o(bp_rst_o)
  );

  // vector: {reload[15:0], res[2:0], target, sysctl, exp_board, exp_bp}
  localparam logic [22:0] VEC [0:5] = '{
    {16'd5, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0},
    {16'd3, 3'd1, 1'b1, 1'b0, 1'b0, 1'b1},
    {16'd2, 3'd2, 1'b0, 1'b1, 1'b1, 1'b1},
    {16'd4, 3'd3, 1'b1, 1'b1, 1'b0, 1'b1},
    {16'd0, 3'd1, 1'b0, 1'b0, 1'b1, 1'b0},
    {16'd7, 3'd0, 1'b1, 1'b0, 1'b0, 1'b1}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [CNT_W-1:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [CNT_W-1:0] d);
    @(negedge clk);
    rd_en_i = 1'b1; rd_addr_i = a;
    @(negedge clk);
    rd_en_i = 1'b0;
    d = rd_data_o;
  endtask

  // counts negedges from the call until a reset output is high
  task automatic wait_rst(output int cyc);
    cyc = 0;
    while (!(board_rst_o || bp_rst_o) && cyc < 3000) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic pulse_width(output int w);
    w = 0;
    while ((board_rst_o || bp_rst_o) && w < 100) begin
      w++;
      @(negedge clk);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual 1 expected 0 (run hung)");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [CNT_W-1:0] d;
    int cyc;
    int w;
    int per;
    int exp_cyc;

    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    chk(!board_rst_o && !bp_rst_o, "R1 outputs low", int'({board_rst_o, bp_rst_o}), 0);
    rd(2'd0, d); chk(d == 16'hFFFF, "R1 reload", int'(d), 16'hFFFF);
    rd(2'd1, d); chk(d == 16'h0, "R1 ctrl", int'(d), 0);
    rd(2'd2, d); chk(d == 16'h0, "R1 res", int'(d), 0);
    rd(2'd3, d); chk(d == 16'hFFFF, "R10 count after reset", int'(d), 16'hFFFF);

    // table walk: R3 timing, R5/R6/R7 target, R8 width, R9/R10 afterwards
    for (int i = 0; i < 6; i++) begin
      logic [15:0] n;
      logic [2:0]  r;
      n = VEC[i][22:7];
      r = VEC[i][6:4];
      sys_ctrl_i = VEC[i][2];
      wr(2'd2, {13'd0, r});
      wr(2'd0, n);
      wr(2'd1, {14'd0, VEC[i][3], 1'b1});
      per = TB_TICK << r;
      exp_cyc = (n == 0) ? per : int'(n) * per;
      wait_rst(cyc);
      chk(cyc == exp_cyc, $sformatf("R3 expiry time v%0d", i), cyc, exp_cyc);
      chk(board_rst_o == VEC[i][1], $sformatf("R5 R7 board output v%0d", i),
          int'(board_rst_o), int'(VEC[i][1]));
      chk(bp_rst_o == VEC[i][0], $sformatf("R6 R7 backplane output v%0d", i),
          int'(bp_rst_o), int'(VEC[i][0]));
      pulse_width(w);
      chk(w == TB_PULSE, $sformatf("R8 pulse width v%0d", i), w, TB_PULSE);
      rd(2'd1, d);
      chk(d[0] == 1'b0, $sformatf("R9 enable cleared v%0d", i), int'(d[0]), 0);
      rd(2'd3, d);
      chk(d == 16'd0, $sformatf("R10 count zero v%0d", i), int'(d), 0);
      rd(2'd2, d);
      chk(d == {13'd0, r}, $sformatf("R10 res readback v%0d", i), int'(d), int'(r));
    end
    sys_ctrl_i = 1'b0;

    // R2: kick postpones expiry
    wr(2'd2, 16'd0);
    wr(2'd0, 16'd4);
    wr(2'd1, 16'h0001);
    repeat (8) @(negedge clk);
    wr(2'd0, 16'd4);
    chk(!board_rst_o && !bp_rst_o, "R2 no reset before kick interval", int'(board_rst_o), 0);
    wait_rst(cyc);
    chk(cyc == 4 * TB_TICK, "R2 expiry after kick", cyc, 4 * TB_TICK);
    pulse_width(w);
    rd(2'd0, d);
    chk(d == 16'd4, "R10 reload readback", int'(d), 4);

    // R4: disabling freezes the count with no reset
    wr(2'd0, 16'd20);
    wr(2'd1, 16'h0001);
    repeat (8) @(negedge clk);
    wr(2'd1, 16'h0000);
    cyc = 0;
    w = 0;
    repeat (80) begin
      @(negedge clk);
      if (board_rst_o || bp_rst_o) w++;
    end
    chk(w == 0, "R4 no reset while disabled", w, 0);
    rd(2'd3, d);
    chk(d == 16'd17, "R4 R10 count frozen", int'(d), 17);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule